// File: doc/BRIEF.md
# Machine State Register Write Unit

This block keeps the 64-bit machine state word of a processor core and applies the architected update rules whenever software moves a general-purpose value into it. A write does not overwrite the whole register. Each bit group has its own rule. Some bits take the source value directly. Some are forced on by another source bit. Two can be blocked by bits that are already set in the register. Some bits are never touched. The register value is always visible on the output, and that output also serves as the read path.

The write port has three controls. `light_mode` selects a fast update that changes only two bits. `wide_form` selects the 64-bit variant, which also loads the upper section, in place of the 32-bit variant. `wr_en` is the write strobe. Bit numbers in this brief use MSB-0 numbering: bit k is `state_q[63-k]`.

Top module: `mstate_reg`

## Requirements
- R1: When `wr_en`=1 and `light_mode`=1, only bits 48 and 62 take the source value. All other bits keep their values, whatever `wide_form` is.
- R2: When `wr_en`=1 and `light_mode`=0, new bit 48 = source bit 48 OR source bit 49.
- R3: When `wr_en`=1 and `light_mode`=0, new bit 58 = (source 58 OR source 49) AND NOT (old 41 AND old 3 AND NOT source 49). Bit 59 follows the same rule, using source 59.
- R4: When `wr_en`=1 and `light_mode`=0, bits 32..40, 42..47, 49..50, 52..57 and 60..62 are copied from the source.
- R5: When `wr_en`=1 and `light_mode`=0, bits 0..28 are copied from the source if `wide_form`=1 and keep their values if `wide_form`=0.
- R6: Bits 29..31, 41, 51 and 63 never change after reset.
- R7: When `wr_en`=0, the register holds its value.
- R8: While `rst_n`=0, the register takes the parameter `RST_VAL`. The output always shows the full register.
- R9: Every new bit is computed from the register state before the write, and all bits change together on the same rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| light_mode | input | 1 | 1 = update only bits 48 and 62 |
| wide_form | input | 1 | 1 = 64-bit variant, which also loads bits 0..28 |
| src | input | 64 | Source value |
| state_q | output | 64 | Current register value (read path) |

## Verification
A write strobed in one cycle shows up on `state_q` after the next rising edge, and only then. Reads are a plain wire from the register, so they have no delay of their own. The bench drives inputs on the falling edge, holds the strobe for exactly one rising edge, and checks at the following falling edge. It compares each bit group against a model that works from the state captured before the write. Idle cycles with random source values are checked one falling edge later for no change.

// File: rtl/mstate_reg.sv
module mstate_reg #(
  parameter logic [63:0] RST_VAL = 64'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        light_mode,
  input  logic        wide_form,
  input  logic [63:0] src,
  output logic [63:0] state_q
);

  function automatic logic [63:0] span(input int lo, input int hi);
    logic [63:0] m;
    m = '0;
    for (int k = lo; k <= hi; k++) m[63-k] = 1'b1;
    return m;
  endfunction

  localparam int B3  = 63 - 3;
  localparam int B41 = 63 - 41;
  localparam int B48 = 63 - 48;
  localparam int B49 = 63 - 49;
  localparam int B58 = 63 - 58;
  localparam int B59 = 63 - 59;

  localparam logic [63:0] LIGHT_M = span(48, 48) | span(62, 62);
  localparam logic [63:0] BASE_M  = span(32, 40) | span(42, 47) | span(49, 50)
                                  | span(52, 57) | span(60, 62);
  localparam logic [63:0] HIGH_M  = span(0, 28);
  localparam logic [63:0] KEEP_M  = span(29, 31) | span(41, 41) | span(51, 51) | span(63, 63);

  logic [63:0] copy_m, nxt;
  logic        guard;

  assign copy_m = light_mode ? LIGHT_M : (BASE_M | (wide_form ? HIGH_M : 64'h0));
  assign guard  = state_q[B41] & state_q[B3] & ~src[B49];

  always_comb begin
    nxt = (state_q & ~copy_m) | (src & copy_m);
    if (!light_mode) begin
      nxt[B48] = src[B48] | src[B49];
      nxt[B58] = (src[B58] | src[B49]) & ~guard;
      nxt[B59] = (src[B59] | src[B49]) & ~guard;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     state_q <= RST_VAL;
    else if (wr_en) state_q <= nxt;
  end

  assert_light_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && light_mode) |-> ((state_q & ~LIGHT_M) == ($past(state_q) & ~LIGHT_M)));

  assert_set48_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && !light_mode && src[B49]) |-> (state_q[B48] && state_q[B49]));

  assert_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && !light_mode && !src[B49] && state_q[B41] && state_q[B3])
      |-> (!state_q[B58] && !state_q[B59]));

  assert_force_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && !light_mode && src[B49]) |-> (state_q[B58] && state_q[B59]));

  assert_narrow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && !light_mode && !wide_form) |-> ((state_q & HIGH_M) == ($past(state_q) & HIGH_M)));

  assert_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q & KEEP_M) == ($past(state_q) & KEEP_M));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(state_q));

endmodule

// File: tb/mstate_reg_test.sv
module mstate_reg_test;
  localparam int PERIOD = 10;
  localparam logic [63:0] RV = 64'h1000_0000_0040_0000;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, light_mode = 1'b0, wide_form = 1'b0;
  logic [63:0] src = '0;
  logic [63:0] state_q;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  mstate_reg #(.RST_VAL(RV)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .light_mode(light_mode),
    .wide_form(wide_form), .src(src), .state_q(state_q));

  function automatic logic b(input logic [63:0] v, input int k);
    return v[63-k];
  endfunction

  function automatic logic [63:0] grp(input int lo, input int hi);
    logic [63:0] m = '0;
    for (int k = lo; k <= hi; k++) m[63-k] = 1'b1;
    return m;
  endfunction

  function automatic logic [63:0] model(input logic [63:0] o, input logic [63:0] s,
                                        input logic l, input logic w);
    logic [63:0] r = o;
    for (int k = 0; k < 64; k++) begin
      if (l) begin
        if (k == 48 || k == 62) r[63-k] = s[63-k];
      end else if (k == 48) r[63-k] = b(s,48) | b(s,49);
      else if (k == 58 || k == 59)
        r[63-k] = (s[63-k] | b(s,49)) & ~(b(o,41) & b(o,3) & ~b(s,49));
      else if ((k >= 32 && k <= 40) || (k >= 42 && k <= 47) || k == 49 || k == 50 ||
               (k >= 52 && k <= 57) || (k >= 60 && k <= 62) || (w && k <= 28))
        r[63-k] = s[63-k];
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [63:0] m, input logic [63:0] exp);
    checks++;
    if ((state_q & m) !== (exp & m)) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, state_q & m, exp & m);
    end
  endtask

  task automatic write(input logic [63:0] s, input logic l, input logic w);
    logic [63:0] old, exp;
    old = state_q;
    exp = model(old, s, l, w);
    src = s; light_mode = l; wide_form = w; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    if (l) check("R1", '1, exp);
    else begin
      check("R2", grp(48,48), exp);
      check("R3", grp(58,59), exp);
      check("R4", grp(32,40)|grp(42,47)|grp(49,50)|grp(52,57)|grp(60,62), exp);
      check("R5", grp(0,28), exp);
      check("R9", '1, exp);
    end
    check("R6", grp(29,31)|grp(41,41)|grp(51,51)|grp(63,63), old);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (2) @(negedge clk);
    check("R8", '1, RV);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8", '1, RV);
    write(64'h0, 1'b0, 1'b0);
    write(64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b1);
    write(64'h0000_0000_0000_0040, 1'b0, 1'b0);
    write(64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b1);
    write(64'h0000_0000_0000_0000, 1'b1, 1'b0);
    write(64'h1000_0000_0000_0030, 1'b0, 1'b1);
    write(64'h0000_0000_0000_0030, 1'b0, 1'b0);
    write(64'h0000_0000_0000_0000, 1'b0, 1'b1);
    write(64'h0000_0000_0000_0030, 1'b0, 1'b0);
    for (int i = 0; i < 400; i++) begin
      logic [63:0] r;
      r = {$urandom, $urandom};
      if (($urandom % 4) == 0) begin
        logic [63:0] hold;
        hold = state_q;
        src = r; light_mode = $urandom; wide_form = $urandom;
        @(negedge clk);
        check("R7", '1, hold);
      end else write(r, ($urandom % 3) == 0, $urandom);
    end
    rst_n = 1'b0;
    @(negedge clk);
    check("R8", '1, RV);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule